// File: doc/BRIEF.md
# Pulse and Quadrature Position Counter

This peripheral counts activity on two external inputs, `sig_a` and `sig_b`, and software controls it through a small register bus. In pulse mode it counts up on each selected edge of `sig_a`, and `sig_b` has no effect. In encoder mode the two inputs form a quadrature pair. The counter moves up or down depending on which input leads the other. The programmed edge selection sets the resolution: four counts per input cycle, or two. The count wraps at a programmable ceiling in both directions.

Software follows a fixed order. While the block is disabled, it writes the configuration. It then sets the enable bit, loads the ceiling and compare registers, and finally sets the start bit. Each accepted ceiling or compare write raises a sticky done flag, and writing a 1 to the clear register drops that flag. Both inputs pass through a two-stage synchronizer before edge detection. The register bus accepts a write on every cycle with no back-pressure. Read data is combinational from the address.

Top module: `pulse_quad_counter`

## Requirements
- R1: After reset, every readable register reads as follows: control 0, configuration 0, compare 0, count 0, status 0, and ceiling all ones.
- R2: The control register is at address 0. Bit 0 is enable and bit 1 is start. Start becomes set only when it is written as 1 while enable is already set. A write that sets enable and start together from the disabled state sets only enable. Writing start as 0 while enabled does not stop the counter. The counter moves only while both bits are set.
- R3: Writing 0 to enable clears start and forces the count to 0.
- R4: The configuration register is at address 1. Bit 0 selects encoder mode, bit 1 selects pulse mode, and bits 3:2 select the edge: 0 rising, 1 falling, 2 or 3 both. Writes to it while enabled are ignored.
- R5: The ceiling register is at address 2 and the compare register is at address 3. Writes to either are accepted only while enabled and are ignored while disabled.
- R6: The status register is at address 5. Bit 0 is set by an accepted ceiling write and bit 1 by an accepted compare write. Both bits stay set until software writes 1 to the same bit of the clear register at address 6.
- R7: In pulse mode (encoder bit 0), the count at address 4 rises by one on each `sig_a` edge that matches the edge selection. Changes on `sig_b` have no effect.
- R8: In encoder mode with both-edge selection, every single-input transition moves the count by one. The count goes up when `sig_a` leads `sig_b` (sequence 00,10,11,01 as {a,b}) and down in the reverse order.
- R9: In encoder mode with rising or falling selection, only transitions in which the changing input goes high (rising) or goes low (falling) move the count. This gives two counts per input cycle.
- R10: A sample in which both inputs change at once moves the count in neither direction.
- R11: Counting up from a value at or above the ceiling gives 0. Counting down from 0 gives the ceiling.
- R12: With both the encoder bit and the pulse bit clear, input activity leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_a | input | 1 | External input A (pulse source, quadrature phase A) |
| sig_b | input | 1 | External input B (quadrature phase B) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |

## Verification
On every cycle, the assertions check four properties. The decoder never signals up and down together, never steps on a sample where both inputs change, and never counts down in pulse mode. The counter wraps correctly at both ends and is cleared while disabled. The register locks hold: configuration cannot change while enabled, and the ceiling cannot change while disabled. A ceiling write that is accepted always raises its done flag. Only the bench scenarios can show that the end-to-end counts are right. They sweep every edge selection in both modes, drive forward and reverse quadrature sequences through both wrap points, and inject illegal double transitions. A model in the bench computes the expected count from the Gray-code distance between samples.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG    = 3'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP    = 3'd3;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;
  localparam logic [ADDR_W-1:0] A_CLR    = 3'd6;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_ALT  = 2'd3
  } edge_sel_e;

  // packed: pol in [3:2], pulse in [1], quad in [0]
  typedef struct packed {
    edge_sel_e pol;
    logic      pulse;
    logic      quad;
  } cfg_t;
endpackage

// File: rtl/qcnt_sync.sv
module qcnt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qcnt_decoder.sv
module qcnt_decoder
  import qcnt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  input  cfg_t cfg,
  input  logic run,
  output logic step_up,
  output logic step_dn
);
  logic pa, pb;
  logic da, db, moved, dir_up, hit_q, hit_p;

  function automatic logic edge_ok(input edge_sel_e p, input logic lvl);
    case (p)
      EDGE_RISE: return lvl;
      EDGE_FALL: return !lvl;
      default:   return 1'b1;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa <= 1'b0;
      pb <= 1'b0;
    end else begin
      pa <= a;
      pb <= b;
    end
  end

  always_comb begin
    da     = a ^ pa;
    db     = b ^ pb;
    moved  = da ? a : b;
    dir_up = da ? (a != b) : (b == a);
    hit_q  = (da ^ db) && edge_ok(cfg.pol, moved);
    hit_p  = da && edge_ok(cfg.pol, a);
    step_up = 1'b0;
    step_dn = 1'b0;
    if (run) begin
      if (cfg.quad) begin
        step_up = hit_q && dir_up;
        step_dn = hit_q && !dir_up;
      end else if (cfg.pulse) begin
        step_up = hit_p;
      end
    end
  end

  // R8
  one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn}));

  // R10
  double_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (da && db) |-> (!step_up && !step_dn));

  // R7
  pulse_no_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.quad |-> !step_dn);
endmodule

// File: rtl/qcnt_core.sv
module qcnt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic [CNT_W-1:0] ceiling,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (!enable) begin
      count <= '0;
    end else if (step_up) begin
      count <= (count >= ceiling) ? '0 : count + 1'b1;
    end else if (step_dn) begin
      count <= (count == '0) ? ceiling : count - 1'b1;
    end
  end

  // R11
  wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && step_up && count >= ceiling) |=> count == '0);

  // R11
  wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && step_dn && count == '0) |=> count == $past(ceiling));

  // R3
  cleared_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> count == '0);

  // R12
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !step_up && !step_dn) |=> $stable(count));
endmodule

// File: rtl/pulse_quad_counter.sv
module pulse_quad_counter
  import qcnt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_a,
  input  logic              sig_b,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata
);
  localparam int CFG_W = $bits(cfg_t);

  logic             enable_q, start_q, rel_ok_q, cmp_ok_q;
  cfg_t             cfg_q;
  logic [CNT_W-1:0] ceil_q, cmp_q, count;
  logic [1:0]       ab_sync;
  logic             run, step_up, step_dn;
  logic             wr_ctrl, wr_cfg, wr_rel, wr_cmp, wr_clr;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_cfg  = reg_wr && (reg_addr == A_CFG);
  assign wr_rel  = reg_wr && (reg_addr == A_RELOAD);
  assign wr_cmp  = reg_wr && (reg_addr == A_CMP);
  assign wr_clr  = reg_wr && (reg_addr == A_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      start_q  <= 1'b0;
      cfg_q    <= '0;
      ceil_q   <= '1;
      cmp_q    <= '0;
      rel_ok_q <= 1'b0;
      cmp_ok_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        enable_q <= reg_wdata[0];
        if (!reg_wdata[0]) start_q <= 1'b0;
        else if (enable_q && reg_wdata[1]) start_q <= 1'b1;
      end
      if (wr_cfg && !enable_q) cfg_q <= cfg_t'(reg_wdata[CFG_W-1:0]);
      if (wr_rel && enable_q) begin
        ceil_q   <= reg_wdata;
        rel_ok_q <= 1'b1;
      end
      if (wr_cmp && enable_q) begin
        cmp_q    <= reg_wdata;
        cmp_ok_q <= 1'b1;
      end
      if (wr_clr) begin
        if (reg_wdata[0]) rel_ok_q <= 1'b0;
        if (reg_wdata[1]) cmp_ok_q <= 1'b0;
      end
    end
  end

  assign run = enable_q && start_q;

  qcnt_sync #(.W(2), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sig_b, sig_a}), .q(ab_sync)
  );

  qcnt_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .a(ab_sync[0]), .b(ab_sync[1]),
    .cfg(cfg_q), .run(run), .step_up(step_up), .step_dn(step_dn)
  );

  qcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .enable(enable_q), .step_up(step_up),
    .step_dn(step_dn), .ceiling(ceil_q), .count(count)
  );

  always_comb begin
    case (reg_addr)
      A_CTRL:   reg_rdata = {{(CNT_W-2){1'b0}}, start_q, enable_q};
      A_CFG:    reg_rdata = {{(CNT_W-CFG_W){1'b0}}, cfg_q};
      A_RELOAD: reg_rdata = ceil_q;
      A_CMP:    reg_rdata = cmp_q;
      A_COUNT:  reg_rdata = count;
      A_STAT:   reg_rdata = {{(CNT_W-2){1'b0}}, cmp_ok_q, rel_ok_q};
      default:  reg_rdata = '0;
    endcase
  end

  // R4
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable_q |=> $stable(cfg_q));

  // R5
  reload_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rel && !enable_q) |=> $stable(ceil_q));

  // R6
  reload_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rel && enable_q) |=> rel_ok_q);

  // R2
  start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_q) |-> $past(enable_q));
endmodule

// File: tb/pulse_quad_counter_tb.sv
module pulse_quad_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sig_a = 1'b0, sig_b = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0, m_ceil = 65535, m_pol = 0;
  bit m_quad = 0, m_pulse = 0, m_run = 0;
  int gpos = 0;

  always #2 clk = ~clk;

  pulse_quad_counter u_dut (
    .clk(clk), .rst_n(rst_n), .sig_a(sig_a), .sig_b(sig_b),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic int gidx(input logic a, input logic b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int mstep(input logic oa, ob, na, nb);
    int d;
    logic lvl;
    bit hit;
    if (m_quad) begin
      d = (gidx(na, nb) - gidx(oa, ob) + 4) % 4;
      if (d == 0 || d == 2) return 0;
      lvl = (oa != na) ? na : nb;
      hit = (m_pol == 0) ? lvl : (m_pol == 1) ? !lvl : 1'b1;
      if (!hit) return 0;
      return (d == 1) ? 1 : -1;
    end else if (m_pulse) begin
      if (oa == na) return 0;
      hit = (m_pol == 0) ? na : (m_pol == 1) ? !na : 1'b1;
      return hit ? 1 : 0;
    end
    return 0;
  endfunction

  task automatic drive(input logic na, input logic nb);
    int s;
    s = mstep(sig_a, sig_b, na, nb);
    if (m_run) begin
      if (s == 1) m_cnt = (m_cnt >= m_ceil) ? 0 : m_cnt + 1;
      else if (s == -1) m_cnt = (m_cnt == 0) ? m_ceil : m_cnt - 1;
    end
    @(negedge clk);
    sig_a = na; sig_b = nb;
    repeat (5) @(negedge clk);
  endtask

  task automatic gstep(input int dir);
    gpos = (gpos + dir + 4) % 4;
    case (gpos)
      0: drive(1'b0, 1'b0);
      1: drive(1'b1, 1'b0);
      2: drive(1'b1, 1'b1);
      default: drive(1'b0, 1'b1);
    endcase
  endtask

  task automatic configure(input int pol, input bit q, input bit p);
    wr(3'd0, 16'd0);
    m_run = 0; m_cnt = 0;
    wr(3'd1, 16'((pol << 2) | (int'(p) << 1) | int'(q)));
    m_pol = pol; m_quad = q; m_pulse = p;
    wr(3'd0, 16'd1);
    wr(3'd0, 16'd3);
    m_run = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check("R1 ctrl", v, 16'd0);
    rd(3'd1, v); check("R1 cfg", v, 16'd0);
    rd(3'd2, v); check("R1 ceiling", v, 16'hFFFF);
    rd(3'd3, v); check("R1 compare", v, 16'd0);
    rd(3'd4, v); check("R1 count", v, 16'd0);
    rd(3'd5, v); check("R1 status", v, 16'd0);

    // R5 writes ignored while disabled
    wr(3'd2, 16'd7); rd(3'd2, v); check("R5 ceiling locked", v, 16'hFFFF);
    wr(3'd3, 16'd7); rd(3'd3, v); check("R5 compare locked", v, 16'd0);
    rd(3'd5, v); check("R6 no flag when ignored", v, 16'd0);

    // R2 start with enable from disabled sets only enable
    wr(3'd0, 16'd3); rd(3'd0, v); check("R2 start ignored", v, 16'd1);
    wr(3'd0, 16'd3); rd(3'd0, v); check("R2 start set", v, 16'd3);
    wr(3'd0, 16'd1); rd(3'd0, v); check("R2 start kept", v, 16'd3);

    // R5/R6 accepted writes and flags
    wr(3'd2, 16'd9); m_ceil = 9;
    rd(3'd2, v); check("R5 ceiling written", v, 16'd9);
    rd(3'd5, v); check("R6 reload flag", v, 16'd1);
    wr(3'd3, 16'd4); rd(3'd3, v); check("R5 compare written", v, 16'd4);
    rd(3'd5, v); check("R6 both flags", v, 16'd3);
    wr(3'd6, 16'd1); rd(3'd5, v); check("R6 clear reload", v, 16'd2);
    wr(3'd6, 16'd2); rd(3'd5, v); check("R6 clear compare", v, 16'd0);

    // R4 cfg locked while enabled
    wr(3'd1, 16'd5); rd(3'd1, v); check("R4 cfg locked", v, 16'd0);

    // R12 no source selected
    drive(1'b1, 1'b0); drive(1'b0, 1'b1); drive(1'b1, 1'b1);
    rd(3'd4, v); check("R12 idle", v, 16'd0);
    drive(1'b0, 1'b0);

    // R7 pulse mode sweeps (all edge selections), wraps at 9
    for (int pol = 0; pol < 4; pol++) begin
      configure(pol, 1'b0, 1'b1);
      rd(3'd1, v); check("R4 cfg readback", v, 16'((pol << 2) | 2));
      for (int i = 0; i < 13; i++) begin
        drive(~sig_a, sig_b);
        if (i % 3 == 0) drive(sig_a, ~sig_b);
      end
      rd(3'd4, v); check("R7 pulse count", v, 16'(m_cnt));
      wr(3'd0, 16'd0); m_run = 0; m_cnt = 0;
      rd(3'd4, v); check("R3 count cleared", v, 16'd0);
      rd(3'd0, v); check("R3 start cleared", v, 16'd0);
      drive(1'b0, 1'b0);
    end

    // R8/R9/R10/R11 encoder sweeps
    for (int pol = 0; pol < 4; pol++) begin
      configure(pol, 1'b1, 1'b0);
      gpos = 0;
      for (int i = 0; i < 11; i++) gstep(1);
      rd(3'd4, v);
      check(pol >= 2 ? "R8 forward" : "R9 forward", v, 16'(m_cnt));
      for (int i = 0; i < 27; i++) gstep(-1);
      rd(3'd4, v); check("R11 reverse wrap", v, 16'(m_cnt));
      for (int i = 0; i < 4; i++) begin
        gpos = (gpos + 2) % 4;
        drive(~sig_a, ~sig_b);
      end
      rd(3'd4, v); check("R10 double change", v, 16'(m_cnt));
      drive(1'b0, 1'b0); gpos = 0;
    end

    // R11 count above a lowered ceiling wraps to 0
    configure(2, 1'b1, 1'b0);
    gpos = 0;
    for (int i = 0; i < 6; i++) gstep(1);
    wr(3'd2, 16'd3); m_ceil = 3;
    gstep(1);
    rd(3'd4, v); check("R11 above ceiling", v, 16'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule